// File: doc/BRIEF.md
# DMA Block Buffer Coherence Agent

This block tracks the coherence of the small set of 32-byte blocks that an I/O module has fetched from memory for DMA. It watches every CPU transaction on the system bus, compares the block address with each buffered entry, and responds so that the buffered copies never go stale. The CPUs update each other's copies on writes. This agent does something different: a write that hits one of its blocks makes it drop that copy and fetch the block again from memory.

On a CPU read that hits a held block, the agent raises a shared indication one cycle later. This tells the reading CPU that another holder of the block exists. The agent never holds modified data, so it never claims ownership and never supplies data on the bus. Each entry can be held, waiting for a re-read, re-read in flight, or free. Entries that wait for a re-read are offered to the bus commander one at a time through a valid/ready request port, always starting with the lowest entry index. The DMA engine loads entries through an allocate port, reports completed re-reads through a fill-done port, and frees entries it no longer needs through a release port.

Top module: `iobuf_coh_agent`

## Requirements
- R1: After reset no entry is held or pending: `rd_req_valid` and `snp_shared` are both 0.
- R2: A read snoop (`snp_write`=0) whose address falls anywhere in a held block, at any byte offset 0..31, drives `snp_shared` to 1 in the following cycle. An address in any other 32-byte block gives 0.
- R3: A write snoop never raises `snp_shared`. A write snoop that hits a held block invalidates it, so later read snoops to that block see `snp_shared`=0.
- R4: An entry invalidated by a write hit requests a re-read. `rd_req_valid`=1, `rd_req_idx` is the entry number, and `rd_req_addr` is the block base with bits [4:0] zero.
- R5: Among the entries waiting for a re-read, the lowest entry index is requested first. A request stays unchanged while `rd_req_ready` is 0, and only one request is offered at a time.
- R6: When a request is accepted (`rd_req_valid` and `rd_req_ready` both 1 at a clock edge), the entry stops requesting. A later `fill_done_valid` for that index makes the entry held again.
- R7: A write hit on an entry whose re-read is in flight means the fill must not make the entry held. On fill completion the entry requests a re-read again.
- R8: If an allocate and a write snoop to the newly allocated block occur in the same cycle, the write wins. The entry is left waiting for a re-read of the new address, not held.
- R9: A release frees the entry, dropping both a held block and a pending re-read request.
- R10: A write hit in the same cycle that the entry's request is accepted causes another re-read after that fill completes.
- R11: A write snoop to a block that no entry holds changes no entry. No request appears, and held blocks still report shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | A CPU bus transaction is presented for snooping |
| snp_write | input | 1 | 1 = write transaction, 0 = read transaction |
| snp_addr | input | 32 | Byte address of the snooped transaction |
| snp_shared | output | 1 | Shared response, one cycle after a read snoop hit |
| alloc_valid | input | 1 | Load an entry with a freshly fetched block |
| alloc_idx | input | 2 | Entry to load |
| alloc_addr | input | 32 | Address of the loaded block |
| release_valid | input | 1 | Free an entry |
| release_idx | input | 2 | Entry to free |
| rd_req_valid | output | 1 | A re-read is requested |
| rd_req_ready | input | 1 | Bus commander accepts the request |
| rd_req_addr | output | 32 | Block-aligned address to re-read |
| rd_req_idx | output | 2 | Entry the re-read belongs to |
| fill_done_valid | input | 1 | A re-read for an entry has completed |
| fill_done_idx | input | 2 | Entry whose re-read has completed |

## Verification
Read snoops sweep every byte offset of a held block, plus the addresses just outside it. This separates block-granular matching from exact or mis-masked address matching. Write hits are placed on entries in scattered index order, with the ready input held low and then high. This shows whether requests follow index priority and whether they wait for acceptance. Write snoops are also made to collide with an allocate, an accept and an in-flight fill in the same cycle. Each collision is resolved toward invalidation, which a design that lets the fill or the accept win would get wrong.

// File: rtl/iobuf_coh_pkg.sv
package iobuf_coh_pkg;

    parameter int ADDR_W    = 32;
    parameter int BLK_BYTES = 32;

    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int BLK_W = ADDR_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BLK_W-1:0]  blk_t;

    // Per-entry coherence record.
    // valid    : block held and usable.
    // refetch  : block must be fetched again.
    // inflight : a re-read has been handed to the commander.
    // refetch with inflight set means the in-flight fill is already stale.
    typedef struct packed {
        logic valid;
        logic refetch;
        logic inflight;
        blk_t blk;
    } ent_t;

    typedef struct packed {
        logic vld;
        logic wr;
        blk_t blk;
    } snoop_t;

    function automatic blk_t blk_of(addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic addr_t base_of(blk_t b);
        return {b, {OFF_W{1'b0}}};
    endfunction

    function automatic ent_t ent_free();
        ent_t e;
        e.valid    = 1'b0;
        e.refetch  = 1'b0;
        e.inflight = 1'b0;
        e.blk      = '0;
        return e;
    endfunction

    function automatic logic ent_tracked(ent_t e);
        return e.valid | e.refetch | e.inflight;
    endfunction

endpackage

// File: rtl/iobuf_entry.sv
module iobuf_entry
    import iobuf_coh_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  snoop_t snp,
    input  logic   alloc_me,
    input  blk_t   alloc_blk,
    input  logic   release_me,
    input  logic   accept_me,
    input  logic   done_me,
    output ent_t   ent_q,
    output logic   rd_hit,
    output logic   need
);

    ent_t ent_d;
    logic blk_match;
    logic wr_hit;
    logic alloc_wr_clash;

    assign blk_match      = ent_q.blk == snp.blk;
    assign wr_hit         = snp.vld & snp.wr & ent_tracked(ent_q) & blk_match;
    assign alloc_wr_clash = snp.vld & snp.wr & (snp.blk == alloc_blk);
    assign rd_hit         = snp.vld & ~snp.wr & ent_q.valid & blk_match;
    assign need           = ent_q.refetch & ~ent_q.inflight;

    always_comb begin
        ent_d = ent_q;
        if (accept_me) begin
            ent_d.inflight = 1'b1;
            ent_d.refetch  = 1'b0;
        end
        if (done_me && ent_q.inflight) begin
            ent_d.inflight = 1'b0;
            ent_d.valid    = ~ent_q.refetch;
        end
        if (wr_hit) begin
            ent_d.valid   = 1'b0;
            ent_d.refetch = 1'b1;
        end
        if (alloc_me) begin
            ent_d.blk      = alloc_blk;
            ent_d.inflight = 1'b0;
            ent_d.valid    = ~alloc_wr_clash;
            ent_d.refetch  = alloc_wr_clash;
        end
        if (release_me) begin
            ent_d = ent_free();
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= ent_free();
        end else begin
            ent_q <= ent_d;
        end
    end

endmodule

// File: rtl/iobuf_pick.sv
module iobuf_pick #(
    parameter int N     = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/iobuf_resp.sv
module iobuf_resp #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] rd_hits,
    output logic         shared_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shared_q <= 1'b0;
        end else begin
            shared_q <= |rd_hits;
        end
    end

endmodule

// File: rtl/iobuf_coh_agent.sv
module iobuf_coh_agent
    import iobuf_coh_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    input  logic              alloc_valid,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              release_valid,
    input  logic [IDX_W-1:0]  release_idx,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [IDX_W-1:0]  rd_req_idx,
    input  logic              fill_done_valid,
    input  logic [IDX_W-1:0]  fill_done_idx
);

    snoop_t                 snp;
    ent_t                   ents [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] rd_hits;
    logic [NUM_ENTRIES-1:0] need_vec;
    logic                   accept;
    blk_t                   alloc_blk;

    assign snp.vld   = snp_valid;
    assign snp.wr    = snp_write;
    assign snp.blk   = blk_of(snp_addr);
    assign alloc_blk = blk_of(alloc_addr);
    assign accept    = rd_req_valid & rd_req_ready;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        iobuf_entry u_ent (
            .clk        (clk),
            .rst        (rst),
            .snp        (snp),
            .alloc_me   (alloc_valid && alloc_idx == IDX_W'(g)),
            .alloc_blk  (alloc_blk),
            .release_me (release_valid && release_idx == IDX_W'(g)),
            .accept_me  (accept && rd_req_idx == IDX_W'(g)),
            .done_me    (fill_done_valid && fill_done_idx == IDX_W'(g)),
            .ent_q      (ents[g]),
            .rd_hit     (rd_hits[g]),
            .need       (need_vec[g])
        );
    end

    iobuf_pick #(.N(NUM_ENTRIES)) u_pick (
        .req (need_vec),
        .any (rd_req_valid),
        .idx (rd_req_idx)
    );

    assign rd_req_addr = base_of(ents[rd_req_idx].blk);

    iobuf_resp #(.N(NUM_ENTRIES)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .rd_hits  (rd_hits),
        .shared_q (snp_shared)
    );

endmodule

// File: rtl/iobuf_coh_chk.sv
module iobuf_coh_chk
    import iobuf_coh_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   snp_valid,
    input logic                   snp_write,
    input logic                   snp_shared,
    input logic                   alloc_valid,
    input logic                   release_valid,
    input logic                   rd_req_valid,
    input logic                   rd_req_ready,
    input logic [ADDR_W-1:0]      rd_req_addr,
    input logic [IDX_W-1:0]       rd_req_idx,
    input logic                   fill_done_valid,
    input logic [NUM_ENTRIES-1:0] need_vec
);

    logic [NUM_ENTRIES-1:0] below_mask;
    assign below_mask = (NUM_ENTRIES'(1) << rd_req_idx) - NUM_ENTRIES'(1);

    // R2
    shared_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        snp_shared |-> $past(snp_valid && !snp_write));

    // R3
    write_never_shared_chk: assert property (@(posedge clk) disable iff (rst)
        $past(snp_valid && snp_write) |-> !snp_shared);

    // R4
    req_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> rd_req_addr[OFF_W-1:0] == '0);

    // R5
    lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> (need_vec & below_mask) == '0);

    // R6
    accept_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && rd_req_ready && !snp_valid && !alloc_valid && !release_valid)
        |=> !(rd_req_valid && rd_req_idx == $past(rd_req_idx)));

    // R4
    req_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_req_valid) |-> $past((snp_valid && snp_write) || fill_done_valid));

endmodule

bind iobuf_coh_agent iobuf_coh_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .snp_valid       (snp_valid),
    .snp_write       (snp_write),
    .snp_shared      (snp_shared),
    .alloc_valid     (alloc_valid),
    .release_valid   (release_valid),
    .rd_req_valid    (rd_req_valid),
    .rd_req_ready    (rd_req_ready),
    .rd_req_addr     (rd_req_addr),
    .rd_req_idx      (rd_req_idx),
    .fill_done_valid (fill_done_valid),
    .need_vec        (need_vec)
);

// File: tb/iobuf_coh_agent_tb.sv
`timescale 1ns/1ps
module iobuf_coh_agent_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        snp_valid = 1'b0, snp_write = 1'b0;
    logic [31:0] snp_addr = '0;
    logic        snp_shared;
    logic        alloc_valid = 1'b0;
    logic [1:0]  alloc_idx = '0;
    logic [31:0] alloc_addr = '0;
    logic        release_valid = 1'b0;
    logic [1:0]  release_idx = '0;
    logic        rd_req_valid, rd_req_ready = 1'b0;
    logic [31:0] rd_req_addr;
    logic [1:0]  rd_req_idx;
    logic        fill_done_valid = 1'b0;
    logic [1:0]  fill_done_idx = '0;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    iobuf_coh_agent dut_i (.*);

    function automatic logic [31:0] base(int i);
        return 32'h0004_0000 + 32'(i) * 32'h100;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic snoop(input bit wr, input logic [31:0] a);
        snp_valid = 1'b1; snp_write = wr; snp_addr = a;
        cyc();
        snp_valid = 1'b0; snp_write = 1'b0;
    endtask

    task automatic alloc(input int i, input logic [31:0] a);
        alloc_valid = 1'b1; alloc_idx = 2'(i); alloc_addr = a;
        cyc();
        alloc_valid = 1'b0;
    endtask

    task automatic accept1();
        rd_req_ready = 1'b1;
        cyc();
        rd_req_ready = 1'b0;
    endtask

    task automatic done(input int i);
        fill_done_valid = 1'b1; fill_done_idx = 2'(i);
        cyc();
        fill_done_valid = 1'b0;
    endtask

    task automatic rel(input int i);
        release_valid = 1'b1; release_idx = 2'(i);
        cyc();
        release_valid = 1'b0;
    endtask

    task automatic expect_req(input string req, input int i, input logic [31:0] a);
        chk(rd_req_valid === 1'b1, req, 32'(rd_req_valid), 1);
        chk(rd_req_idx === 2'(i), req, 32'(rd_req_idx), 32'(i));
        chk(rd_req_addr === a, req, rd_req_addr, a);
    endtask

    task automatic expect_shared(input string req, input logic [31:0] a, input bit exp);
        snoop(1'b0, a);
        chk(snp_shared === exp, req, 32'(snp_shared), 32'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1
        chk(rd_req_valid === 1'b0, "R1 req", 32'(rd_req_valid), 0);
        chk(snp_shared === 1'b0, "R1 shared", 32'(snp_shared), 0);

        for (int i = 0; i < 4; i++) alloc(i, base(i) + 32'(i));

        // R2: every offset of entry 0, a fixed offset for the others, neighbours miss
        for (int off = 0; off < 32; off++) expect_shared("R2 offset", base(0) + 32'(off), 1'b1);
        for (int i = 1; i < 4; i++) expect_shared("R2 entry", base(i) + 32'd7, 1'b1);
        expect_shared("R2 next block", base(0) + 32'd32, 1'b0);
        expect_shared("R2 prev block", base(0) - 32'd1, 1'b0);

        // R11
        snoop(1'b1, base(0) + 32'd32);
        chk(rd_req_valid === 1'b0, "R11 req", 32'(rd_req_valid), 0);
        expect_shared("R11 still held", base(0), 1'b1);

        // R3 / R4
        snoop(1'b1, base(1) + 32'd4);
        chk(snp_shared === 1'b0, "R3 write shared", 32'(snp_shared), 0);
        expect_req("R4 request", 1, base(1));
        expect_shared("R3 invalidated", base(1), 1'b0);

        // R5: held while not ready, lowest index first
        for (int k = 0; k < 3; k++) begin
            cyc();
            expect_req("R5 hold", 1, base(1));
        end
        snoop(1'b1, base(3) + 32'd31);
        expect_req("R5 order", 1, base(1));
        snoop(1'b1, base(0));
        expect_req("R5 lowest", 0, base(0));
        rd_req_ready = 1'b1;
        cyc();
        expect_req("R5 second", 1, base(1));
        cyc();
        expect_req("R5 third", 3, base(3));
        cyc();
        rd_req_ready = 1'b0;
        // R6
        chk(rd_req_valid === 1'b0, "R6 accepted", 32'(rd_req_valid), 0);
        expect_shared("R6 in flight", base(0), 1'b0);
        done(0); done(1); done(3);
        chk(rd_req_valid === 1'b0, "R6 no req", 32'(rd_req_valid), 0);
        for (int i = 0; i < 4; i++) expect_shared("R6 refilled", base(i), 1'b1);

        // R7
        snoop(1'b1, base(2));
        expect_req("R7 request", 2, base(2));
        accept1();
        snoop(1'b1, base(2) + 32'd9);
        chk(rd_req_valid === 1'b0, "R7 in flight", 32'(rd_req_valid), 0);
        done(2);
        expect_req("R7 re-request", 2, base(2));
        expect_shared("R7 not held", base(2), 1'b0);
        accept1(); done(2);
        expect_shared("R7 held", base(2), 1'b1);

        // R10
        snoop(1'b1, base(1));
        expect_req("R10 request", 1, base(1));
        rd_req_ready = 1'b1; snp_valid = 1'b1; snp_write = 1'b1; snp_addr = base(1) + 32'd3;
        cyc();
        rd_req_ready = 1'b0; snp_valid = 1'b0; snp_write = 1'b0;
        chk(rd_req_valid === 1'b0, "R10 in flight", 32'(rd_req_valid), 0);
        done(1);
        expect_req("R10 re-request", 1, base(1));
        accept1(); done(1);
        expect_shared("R10 held", base(1), 1'b1);

        // R8
        alloc_valid = 1'b1; alloc_idx = 2'd3; alloc_addr = 32'h0009_0010;
        snp_valid = 1'b1; snp_write = 1'b1; snp_addr = 32'h0009_0008;
        cyc();
        alloc_valid = 1'b0; snp_valid = 1'b0; snp_write = 1'b0;
        expect_req("R8 clash", 3, 32'h0009_0000);
        expect_shared("R8 not held", 32'h0009_0000, 1'b0);
        accept1(); done(3);
        expect_shared("R8 new block", 32'h0009_001f, 1'b1);
        expect_shared("R8 old block gone", base(3), 1'b0);
        alloc_valid = 1'b1; alloc_idx = 2'd2; alloc_addr = 32'h000a_0000;
        snp_valid = 1'b1; snp_write = 1'b1; snp_addr = 32'h000b_0000;
        cyc();
        alloc_valid = 1'b0; snp_valid = 1'b0; snp_write = 1'b0;
        chk(rd_req_valid === 1'b0, "R8 no clash", 32'(rd_req_valid), 0);
        expect_shared("R8 alloc held", 32'h000a_0004, 1'b1);

        // R9
        snoop(1'b1, base(0));
        expect_req("R9 pending", 0, base(0));
        rel(0);
        chk(rd_req_valid === 1'b0, "R9 pending dropped", 32'(rd_req_valid), 0);
        rel(1);
        expect_shared("R9 held dropped", base(1), 1'b0);
        snoop(1'b1, base(1));
        chk(rd_req_valid === 1'b0, "R9 freed ignores write", 32'(rd_req_valid), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule